// File: doc/BRIEF.md
# Touch ADC Conversion Clock Generator

This block paces a successive-approximation touch-screen converter. It selects one of three tick sources and counts that source's ticks. Once a programmed number of ticks has been counted, it emits a single-cycle conversion strobe. The choice of source follows the audio power state:

- When the audio converters are quiet, the 8 MHz on-chip oscillator tick is used.
- When either audio converter is awake, a master-clock path is used instead. This path takes either the raw master tick or a tick already multiplied by a PLL.

For the oscillator, a two-bit code gives divide-by-1, 2, 4 or 8, for 8, 4, 2 or 1 MHz. For the master-clock path, the divisor is a composite constant picked by a mode bit. When the PLL is off, that constant is also scaled by a four-bit factor.

The block also judges the programmed resolution against the conversion rate and raises a flag when the pair is not usable. The strobe keeps running while the flag is up, and the controller downstream decides how to react. A change of source is only taken at a strobe boundary, and the counter restarts there, so no shortened strobe interval is ever produced.

Top module: `convclk_gen`

## Requirements
- R1: The active source is the oscillator when `audio_adc_on` and `audio_dac_on` are both 0. When either is 1, the active source is the master-clock path. `src_ext` is 1 exactly while the master-clock path is active.
- R2: With the oscillator active, `osc_div` codes 0, 1, 2 and 3 give one strobe per 1, 2, 4 and 8 oscillator ticks respectively.
- R3: With the master path active and `pll_en`=0, one strobe is given per q×130 master ticks when `ext_mode`=0, and per q×204 master ticks when `ext_mode`=1, where q is `q_div`.
- R4: A `q_div` value of 0 acts as 1.
- R5: With the master path active and `pll_en`=1, one strobe is given per 2080 `pll_tick` ticks when `ext_mode`=0, and per 3264 when `ext_mode`=1.
- R6: A change of requested source takes effect only on the cycle that produces a strobe. The counter restarts there, so the first interval on the new source is a full one.
- R7: `conv_stb` is high for one cycle. It rises on the cycle after the tick that completes the count.
- R8: `res_sel` is encoded as 0 = 8 bit, 1 = 10 bit, 2 = 12 bit and 3 = reserved. With the oscillator active, 8 bit is always legal, 10 bit needs `osc_div` of 1 or more, and 12 bit needs `osc_div` of 2 or more. With the master path active, only the reserved code is flagged. The reserved code is always flagged. `res_err` is registered and follows its inputs one cycle later.
- R9: An illegal resolution/rate pair raises `res_err` but does not stop or alter the strobe.
- R10: After reset, `conv_stb`, `src_ext` and `res_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| osc_tick | input | 1 | On-chip 8 MHz oscillator tick enable |
| mclk_tick | input | 1 | External master clock tick enable |
| pll_tick | input | 1 | PLL-multiplied master clock tick enable |
| pll_en | input | 1 | Selects the PLL tick on the master path |
| audio_adc_on | input | 1 | Audio ADC powered |
| audio_dac_on | input | 1 | Audio DAC powered |
| osc_div | input | 2 | Oscillator divide code |
| res_sel | input | 2 | Resolution code |
| ext_mode | input | 1 | Composite divisor select for the master path |
| q_div | input | 4 | Master-path scale factor |
| conv_stb | output | 1 | Conversion clock strobe |
| src_ext | output | 1 | Master path active |
| res_err | output | 1 | Resolution illegal at current rate |

## Verification
A source switch request and a strobe can land in the same cycle. Only that coincidence is allowed to move the source, and it must also zero the counter. The bench raises the power request in the middle of an interval, then confirms at the ports that `src_ext` has not yet moved. After the next strobe it confirms that `src_ext` has moved and that the following interval is the full master-path length. A legality error and a running strobe also coexist: strobe spacing is scored while illegal 12-bit pairs hold `res_err` high.

// File: rtl/convclk_pkg.sv
package convclk_pkg;
  localparam int CNT_W  = 12;
  localparam int Q_W    = 4;
  localparam int ODIV_W = 2;
  localparam int RES_W  = 2;

  localparam int K_DIR_M0 = 130;
  localparam int K_DIR_M1 = 204;
  localparam int K_PLL_M0 = 2080;
  localparam int K_PLL_M1 = 3264;

  typedef enum logic [RES_W-1:0] {
    RES_8B  = 2'd0,
    RES_10B = 2'd1,
    RES_12B = 2'd2,
    RES_RSV = 2'd3
  } res_e;

  function automatic logic [CNT_W-1:0] osc_ratio(input logic [ODIV_W-1:0] code);
    return CNT_W'(1) << code;
  endfunction

  function automatic logic [CNT_W-1:0] ext_ratio(input logic pll, input logic mode,
                                                 input logic [Q_W-1:0] q);
    logic [CNT_W-1:0] qe;
    qe = (q == '0) ? CNT_W'(1) : CNT_W'(q);
    if (pll) return mode ? CNT_W'(K_PLL_M1) : CNT_W'(K_PLL_M0);
    return qe * (mode ? CNT_W'(K_DIR_M1) : CNT_W'(K_DIR_M0));
  endfunction

  function automatic logic res_ok(input logic [RES_W-1:0] res, input logic ext,
                                  input logic [ODIV_W-1:0] code);
    if (res == RES_RSV) return 1'b0;
    if (ext) return 1'b1;
    case (res)
      RES_10B: return code >= ODIV_W'(1);
      RES_12B: return code >= ODIV_W'(2);
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/convclk_src_sel.sv
module convclk_src_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic mclk_tick,
  input  logic pll_tick,
  input  logic pll_en,
  input  logic adc_on,
  input  logic dac_on,
  input  logic wrap_i,
  output logic src_ext_o,
  output logic tick_o
);
  logic want_ext;
  logic src_q;

  assign want_ext = adc_on | dac_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= 1'b0;
    else if (wrap_i) src_q <= want_ext;
  end

  always_comb begin
    if (src_q) tick_o = pll_en ? pll_tick : mclk_tick;
    else       tick_o = osc_tick;
  end

  assign src_ext_o = src_q;

  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(src_q)); // R6
  AST_SRC_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> src_q == $past(want_ext)); // R1
endmodule

// File: rtl/convclk_divider.sv
module convclk_divider #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             wrap_o,
  output logic             stb_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             stb_q;

  assign wrap_o = tick_i && (cnt_q >= ratio_i - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= wrap_o;
      if (wrap_o)      cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign stb_o = stb_q;

  AST_STB_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> $past(tick_i)); // R7
  AST_CNT_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/convclk_legal.sv
module convclk_legal
  import convclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RES_W-1:0]  res_i,
  input  logic              ext_i,
  input  logic [ODIV_W-1:0] code_i,
  output logic              err_o
);
  logic err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= !res_ok(res_i, ext_i, code_i);
  end

  assign err_o = err_q;

  AST_RSV_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    res_i == RES_RSV |=> err_q); // R8
  AST_8BIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    res_i == RES_8B |=> !err_q); // R8
endmodule

// File: rtl/convclk_gen.sv
module convclk_gen
  import convclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              mclk_tick,
  input  logic              pll_tick,
  input  logic              pll_en,
  input  logic              audio_adc_on,
  input  logic              audio_dac_on,
  input  logic [ODIV_W-1:0] osc_div,
  input  logic [RES_W-1:0]  res_sel,
  input  logic              ext_mode,
  input  logic [Q_W-1:0]    q_div,
  output logic              conv_stb,
  output logic              src_ext,
  output logic              res_err
);
  logic             sel_tick;
  logic             wrap_evt;
  logic [CNT_W-1:0] ratio;

  convclk_src_sel u_sel (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .mclk_tick(mclk_tick),
    .pll_tick(pll_tick), .pll_en(pll_en), .adc_on(audio_adc_on),
    .dac_on(audio_dac_on), .wrap_i(wrap_evt), .src_ext_o(src_ext),
    .tick_o(sel_tick)
  );

  assign ratio = src_ext ? ext_ratio(pll_en, ext_mode, q_div) : osc_ratio(osc_div);

  convclk_divider #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_i(sel_tick), .ratio_i(ratio),
    .wrap_o(wrap_evt), .stb_o(conv_stb)
  );

  convclk_legal u_leg (
    .clk(clk), .rst_n(rst_n), .res_i(res_sel), .ext_i(src_ext),
    .code_i(osc_div), .err_o(res_err)
  );

  AST_STB_NEEDS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    conv_stb |-> $past(wrap_evt)); // R7
endmodule

// File: tb/sim_convclk_gen.sv
module sim_convclk_gen;
  logic clk = 0, rst_n = 0;
  logic osc_tick = 0, mclk_tick = 1, pll_tick = 0, pll_en = 0;
  logic audio_adc_on = 0, audio_dac_on = 0, ext_mode = 0;
  logic [1:0] osc_div = 0, res_sel = 0;
  logic [3:0] q_div = 1;
  logic conv_stb, src_ext, res_err;

  convclk_gen u0 (.*);

  always #10 clk = ~clk;

  typedef struct { int exp; string tag; } item_t;
  item_t sq[$];
  int n_cmp = 0, n_bad = 0, cyc = 0, last = 0, nstb = 0;
  bit armed = 0, ph = 0;

  initial forever begin
    @(negedge clk);
    ph = ~ph;
    osc_tick = ph;
    pll_tick = ph;
  end

  initial forever begin
    @(negedge clk);
    cyc++;
    if (conv_stb) begin
      if (armed && sq.size() > 0) begin
        item_t it;
        it = sq.pop_front();
        n_cmp++;
        if (cyc - last != it.exp) begin
          n_bad++;
          $display("FAIL %s spacing actual %0d expected %0d", it.tag, cyc - last, it.exp);
        end
      end
      last = cyc;
      nstb++;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic measure(input int exp, input string tag, input int n);
    int s0;
    armed = 0;
    s0 = nstb;
    wait (nstb >= s0 + 2);
    for (int i = 0; i < n; i++) sq.push_back('{exp, tag});
    armed = 1;
    wait (sq.size() == 0);
    armed = 0;
  endtask

  task automatic next_stb();
    int s0;
    s0 = nstb;
    wait (nstb >= s0 + 1);
  endtask

  initial begin
    int qs[5] = '{0, 1, 2, 7, 15};
    repeat (3) @(negedge clk);
    chk(conv_stb, 0, "R10 stb");
    chk(src_ext, 0, "R10 src");
    chk(res_err, 0, "R10 err");
    rst_n = 1;

    // R2 oscillator divide codes, 8-bit resolution
    for (int c = 0; c < 4; c++) begin
      osc_div = 2'(c);
      measure(2 * (1 << c), "R2", 3);
      chk(res_err, 0, "R8 8bit");
    end

    // R9 strobe keeps running with 12-bit at illegal rates
    res_sel = 2;
    for (int c = 0; c < 4; c++) begin
      osc_div = 2'(c);
      measure(2 * (1 << c), "R9", 2);
      chk(res_err, c < 2, "R9 err");
    end

    // R8 legality table, oscillator source
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        logic e;
        res_sel = 2'(r);
        osc_div = 2'(c);
        e = (r == 3) || (r == 1 && c < 1) || (r == 2 && c < 2);
        repeat (2) @(negedge clk);
        chk(res_err, e, "R8 table");
      end
    res_sel = 0;

    // R6 switch waits for strobe boundary, R1 master path selected
    osc_div = 3; q_div = 1; ext_mode = 0; pll_en = 0;
    next_stb();
    repeat (2) @(negedge clk);
    audio_dac_on = 1;
    @(negedge clk);
    chk(src_ext, 0, "R6 hold");
    armed = 0;
    next_stb();
    sq.push_back('{130, "R6"});
    armed = 1;
    @(negedge clk);
    chk(src_ext, 1, "R1 ext");
    wait (sq.size() == 0);
    armed = 0;

    // R8 master path: only reserved flagged
    res_sel = 2; osc_div = 0;
    repeat (2) @(negedge clk);
    chk(res_err, 0, "R8 ext 12b");
    res_sel = 3;
    repeat (2) @(negedge clk);
    chk(res_err, 1, "R8 ext rsv");
    res_sel = 0;

    // R3 / R4 direct master divisors
    for (int m = 0; m < 2; m++)
      foreach (qs[i]) begin
        int qe;
        ext_mode = m[0];
        q_div = 4'(qs[i]);
        qe = (qs[i] == 0) ? 1 : qs[i];
        measure(qe * (m ? 204 : 130), qs[i] == 0 ? "R4" : "R3", 2);
      end

    // R5 PLL path
    pll_en = 1;
    for (int m = 0; m < 2; m++) begin
      ext_mode = m[0];
      measure(2 * (m ? 3264 : 2080), "R5", 2);
    end

    // R1 back to oscillator after power-down
    audio_dac_on = 0; audio_adc_on = 0; osc_div = 1;
    armed = 0;
    next_stb();
    sq.push_back('{4, "R1"});
    armed = 1;
    @(negedge clk);
    chk(src_ext, 0, "R1 osc");
    wait (sq.size() == 0);
    armed = 0;

    // R7 strobe one cycle wide at divide-by-8
    osc_div = 3;
    next_stb();
    @(negedge clk);
    chk(conv_stb, 0, "R7 width");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule